// File: doc/BRIEF.md
# Rotating-Parity Stripe Update Engine

The engine maintains single-parity protection over a set of `NDISK` block stores arranged as rows. Parity rotates from row to row. A caller hands it a logical block number and a new data word. The engine works out which store and which row hold that block, and which store holds the row's check word. It reads the old data word and the old check word. It then writes the new data word and a check word corrected only in the bits that changed. The other stores in the row are never touched.

The engine has a second operation, rebuild. The caller names a row and a store that has failed. The engine reads every other store of that row in turn, folds the words together with XOR, and presents the recovered word. Each store port carries a read strobe, a write strobe, a row address and a write word, and returns its read word one cycle after the read strobe. The engine accepts one operation at a time through a valid/ready pair and signals completion with a one-cycle `done` pulse.

Top module: `parity_rmw_engine`

## Requirements
- R1: Logical block `b` lives in row `b / (NDISK-1)` at position `b mod (NDISK-1)`. The check word of row `r` sits on store `NDISK-1-(r mod NDISK)`. Data positions 0..NDISK-2 fill the remaining stores in ascending store order.
- R2: A write makes exactly four store accesses, one per cycle, all at the block's row, in this order: read data store, read check store, write data store, write check store. No other store sees a strobe.
- R3: The written check word equals old check XOR old data XOR new data, so the XOR of all stores in every row stays zero.
- R4: The data store receives the new data word unchanged.
- R5: `done` is high for exactly one cycle. For a write it rises in the cycle after the check-word write strobe.
- R6: A rebuild reads each store except the failed one exactly once, in ascending store order, and issues no write. `rebuild_data` then equals the XOR of the words read, which is the lost word.
- R7: While reset is high and in the first idle cycle afterwards, `req_ready` is 1, `done` is 0 and no store strobe is asserted.
- R8: `req_ready` is high only when idle. A `req_valid` raised while busy is ignored, and no extra store access follows the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_rebuild | input | 1 | 1 = rebuild, 0 = small write |
| req_lba | input | LBA_W | Logical block number for a write |
| req_data | input | DATA_W | New data word for a write |
| req_row | input | ROW_W | Row to rebuild |
| req_fail | input | SEL_W | Failed store index for a rebuild |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| rebuild_data | output | DATA_W | Recovered word of the last rebuild |
| dsk_rd_en | output | NDISK | Per-store read strobe |
| dsk_wr_en | output | NDISK | Per-store write strobe |
| dsk_row | output | NDISK*ROW_W | Per-store row address |
| dsk_wdata | output | NDISK*DATA_W | Per-store write word |
| dsk_rdata | input | NDISK*DATA_W | Per-store read word, one cycle after the strobe |

## Verification
The assertions check, on every cycle, the rules about timing and exclusion. At most one store strobe is active at a time. The engine is silent while idle and drops ready after it accepts a request. `done` never lasts two cycles. A rebuild never reads the failed store and never writes. Only the bench scenarios can show the arithmetic and the placement: which store gets the check word for each row, the exact four-access order, the corrected check value and the zero-XOR invariant across every row, and that the rebuilt word matches the store that was declared lost.

// File: rtl/raid_pkg.sv
package raid_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DATA,
    ST_RD_PAR,
    ST_CAP_PAR,
    ST_WR_DATA,
    ST_WR_PAR,
    ST_RB_SCAN
  } eng_state_t;
endpackage

// File: rtl/stripe_map.sv
// Logical block -> (row, data store, check store) with per-row rotation.
module stripe_map #(
  parameter int NDISK = 4,
  parameter int ROW_W = 10,
  parameter int LBA_W = 12,
  parameter int SEL_W = 2
) (
  input  logic [LBA_W-1:0] lba,
  output logic [ROW_W-1:0] row,
  output logic [SEL_W-1:0] data_disk,
  output logic [SEL_W-1:0] par_disk
);
  localparam int DPR = NDISK - 1;

  logic [LBA_W-1:0] row_full;
  logic [SEL_W-1:0] pos;

  always_comb begin
    row_full  = lba / LBA_W'(DPR);
    pos       = SEL_W'(lba % LBA_W'(DPR));
    par_disk  = SEL_W'(NDISK - 1) - SEL_W'(row_full % LBA_W'(NDISK));
    data_disk = (pos < par_disk) ? pos : pos + SEL_W'(1);
    row       = ROW_W'(row_full);
  end
endmodule

// File: rtl/disk_port_drv.sv
// Fans one selected access out to the per-store ports and selects a read word.
module disk_port_drv #(
  parameter int NDISK  = 4,
  parameter int ROW_W  = 10,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic                    rd_go,
  input  logic                    wr_go,
  input  logic [SEL_W-1:0]        sel,
  input  logic [ROW_W-1:0]        row,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [SEL_W-1:0]        rsel,
  input  logic [NDISK*DATA_W-1:0] rdata_bus,
  output logic [NDISK-1:0]        rd_en,
  output logic [NDISK-1:0]        wr_en,
  output logic [NDISK*ROW_W-1:0]  row_bus,
  output logic [NDISK*DATA_W-1:0] wdata_bus,
  output logic [DATA_W-1:0]       rdata_sel
);
  for (genvar g = 0; g < NDISK; g++) begin : g_port
    assign rd_en[g] = rd_go && (sel == SEL_W'(g));
    assign wr_en[g] = wr_go && (sel == SEL_W'(g));
    assign row_bus[g*ROW_W +: ROW_W]     = row;
    assign wdata_bus[g*DATA_W +: DATA_W] = wdata;
  end

  always_comb rdata_sel = rdata_bus[rsel*DATA_W +: DATA_W];
endmodule

// File: rtl/parity_rmw_engine.sv
module parity_rmw_engine
  import raid_pkg::*;
#(
  parameter  int NDISK  = 4,
  parameter  int DATA_W = 32,
  parameter  int ROW_W  = 10,
  parameter  int LBA_W  = 12,
  localparam int SEL_W  = $clog2(NDISK)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_rebuild,
  input  logic [LBA_W-1:0]        req_lba,
  input  logic [DATA_W-1:0]       req_data,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [SEL_W-1:0]        req_fail,
  output logic                    req_ready,
  output logic                    done,
  output logic [DATA_W-1:0]       rebuild_data,
  output logic [NDISK-1:0]        dsk_rd_en,
  output logic [NDISK-1:0]        dsk_wr_en,
  output logic [NDISK*ROW_W-1:0]  dsk_row,
  output logic [NDISK*DATA_W-1:0] dsk_wdata,
  input  logic [NDISK*DATA_W-1:0] dsk_rdata
);
  localparam int CNT_W = $clog2(NDISK + 1);

  eng_state_t        state;
  logic [ROW_W-1:0]  row_q;
  logic [SEL_W-1:0]  dd_q, pd_q, fail_q, prv_sel;
  logic [DATA_W-1:0] new_q, old_d_q, old_p_q, acc_q, rb_q;
  logic [CNT_W-1:0]  scan_q;
  logic              prv_vld, done_q;
  logic              in_rebuild;

  logic [ROW_W-1:0]  map_row;
  logic [SEL_W-1:0]  map_dd, map_pd;

  logic              rd_go, wr_go;
  logic [SEL_W-1:0]  sel, rsel;
  logic [DATA_W-1:0] wdata, rword;

  stripe_map #(.NDISK(NDISK), .ROW_W(ROW_W), .LBA_W(LBA_W), .SEL_W(SEL_W)) map_i (
    .lba(req_lba), .row(map_row), .data_disk(map_dd), .par_disk(map_pd)
  );

  disk_port_drv #(.NDISK(NDISK), .ROW_W(ROW_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) drv_i (
    .rd_go(rd_go), .wr_go(wr_go), .sel(sel), .row(row_q), .wdata(wdata),
    .rsel(rsel), .rdata_bus(dsk_rdata), .rd_en(dsk_rd_en), .wr_en(dsk_wr_en),
    .row_bus(dsk_row), .wdata_bus(dsk_wdata), .rdata_sel(rword)
  );

  // Access decode from the registered state.
  always_comb begin
    rd_go = 1'b0;
    wr_go = 1'b0;
    sel   = dd_q;
    rsel  = dd_q;
    wdata = new_q;
    unique case (state)
      ST_RD_DATA: begin rd_go = 1'b1; sel = dd_q; end
      ST_RD_PAR:  begin rd_go = 1'b1; sel = pd_q; rsel = dd_q; end
      ST_CAP_PAR: rsel = pd_q;
      ST_WR_DATA: begin wr_go = 1'b1; sel = dd_q; wdata = new_q; end
      ST_WR_PAR:  begin wr_go = 1'b1; sel = pd_q; wdata = old_p_q ^ old_d_q ^ new_q; end
      ST_RB_SCAN: begin
        sel   = SEL_W'(scan_q);
        rsel  = prv_sel;
        rd_go = (scan_q < CNT_W'(NDISK)) && (scan_q != CNT_W'(fail_q));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      row_q   <= '0;
      dd_q    <= '0;
      pd_q    <= '0;
      fail_q  <= '0;
      prv_sel <= '0;
      new_q   <= '0;
      old_d_q <= '0;
      old_p_q <= '0;
      acc_q   <= '0;
      rb_q    <= '0;
      scan_q  <= '0;
      prv_vld <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (req_rebuild) begin
            row_q   <= req_row;
            fail_q  <= req_fail;
            scan_q  <= '0;
            acc_q   <= '0;
            prv_vld <= 1'b0;
            state   <= ST_RB_SCAN;
          end else begin
            row_q <= map_row;
            dd_q  <= map_dd;
            pd_q  <= map_pd;
            new_q <= req_data;
            state <= ST_RD_DATA;
          end
        end
        ST_RD_DATA: state <= ST_RD_PAR;
        ST_RD_PAR: begin
          old_d_q <= rword;
          state   <= ST_CAP_PAR;
        end
        ST_CAP_PAR: begin
          old_p_q <= rword;
          state   <= ST_WR_DATA;
        end
        ST_WR_DATA: state <= ST_WR_PAR;
        ST_WR_PAR: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_RB_SCAN: begin
          acc_q   <= acc_q ^ (prv_vld ? rword : '0);
          prv_vld <= rd_go;
          prv_sel <= sel;
          if (scan_q == CNT_W'(NDISK)) begin
            rb_q   <= acc_q ^ (prv_vld ? rword : '0);
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            scan_q <= scan_q + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_rebuild   = (state == ST_RB_SCAN);
  assign req_ready    = (state == ST_IDLE);
  assign done         = done_q;
  assign rebuild_data = rb_q;
endmodule

// File: rtl/rmw_checker.sv
module rmw_checker #(
  parameter int NDISK = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NDISK-1:0] dsk_rd_en,
  input logic [NDISK-1:0] dsk_wr_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic             in_rebuild,
  input logic [SEL_W-1:0] fail_q
);
  // R2: one store access per cycle at most
  p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({dsk_rd_en, dsk_wr_en}) <= 1);

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: accepting a request makes the engine busy
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R7: idle engine drives no store strobe
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dsk_rd_en == '0 && dsk_wr_en == '0));

  // R6: rebuild never reads the failed store and never writes
  p_fail_skip_r6: assert property (@(posedge clk) disable iff (rst)
    in_rebuild |-> (!dsk_rd_en[fail_q] && dsk_wr_en == '0));
endmodule

bind parity_rmw_engine rmw_checker #(.NDISK(NDISK), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .dsk_rd_en(dsk_rd_en), .dsk_wr_en(dsk_wr_en),
  .req_valid(req_valid), .req_ready(req_ready), .done(done),
  .in_rebuild(in_rebuild), .fail_q(fail_q)
);

// File: tb/parity_rmw_engine_tb.sv
`timescale 1ns/1ps
module parity_rmw_engine_tb_top;
  localparam int N    = 4;
  localparam int DW   = 16;
  localparam int RW   = 4;
  localparam int LW   = 6;
  localparam int SW   = 2;
  localparam int ROWS = 1 << RW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_rebuild = 1'b0;
  logic [LW-1:0] req_lba = '0;
  logic [DW-1:0] req_data = '0;
  logic [RW-1:0] req_row = '0;
  logic [SW-1:0] req_fail = '0;
  logic          req_ready, done;
  logic [DW-1:0] rebuild_data;
  logic [N-1:0]  dsk_rd_en, dsk_wr_en;
  logic [N*RW-1:0] dsk_row;
  logic [N*DW-1:0] dsk_wdata, dsk_rdata;

  parity_rmw_engine #(.NDISK(N), .DATA_W(DW), .ROW_W(RW), .LBA_W(LW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rebuild(req_rebuild),
    .req_lba(req_lba), .req_data(req_data), .req_row(req_row), .req_fail(req_fail),
    .req_ready(req_ready), .done(done), .rebuild_data(rebuild_data),
    .dsk_rd_en(dsk_rd_en), .dsk_wr_en(dsk_wr_en), .dsk_row(dsk_row),
    .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata)
  );

  // Store model: one-cycle read latency, consistent stripes after reset.
  logic [DW-1:0] mem [N][ROWS];
  logic [DW-1:0] rdq [N];

  function automatic int par_of(int r);
    return (N - 1) - (r % N);
  endfunction

  function automatic logic [DW-1:0] seed(int d, int r);
    return 16'hA000 ^ DW'(d * 16'h0111) ^ DW'(r * 16'h0203);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        logic [DW-1:0] x;
        x = '0;
        for (int d = 0; d < N; d++)
          if (d != par_of(r)) begin
            mem[d][r] <= seed(d, r);
            x = x ^ seed(d, r);
          end
        mem[par_of(r)][r] <= x;
      end
      for (int d = 0; d < N; d++) rdq[d] <= '0;
    end else begin
      for (int d = 0; d < N; d++) begin
        if (dsk_wr_en[d]) mem[d][dsk_row[d*RW +: RW]] <= dsk_wdata[d*DW +: DW];
        if (dsk_rd_en[d]) rdq[d] <= mem[d][dsk_row[d*RW +: RW]];
      end
    end
  end

  always_comb
    for (int d = 0; d < N; d++) dsk_rdata[d*DW +: DW] = rdq[d];

  // Access log, sampled mid-cycle.
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int            log_n = 0;
  logic          log_wr   [128];
  int            log_disk [128];
  int            log_row  [128];
  logic [DW-1:0] log_data [128];
  int            log_cyc  [128];

  always @(negedge clk) begin
    for (int d = 0; d < N; d++)
      if ((dsk_rd_en[d] || dsk_wr_en[d]) && log_n < 128) begin
        log_wr[log_n]   = dsk_wr_en[d];
        log_disk[log_n] = d;
        log_row[log_n]  = int'(dsk_row[d*RW +: RW]);
        log_data[log_n] = dsk_wdata[d*DW +: DW];
        log_cyc[log_n]  = cyc;
        log_n = log_n + 1;
      end
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int dc);
    dc = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) begin dc = cyc; return; end
    end
    chk(1'b0, "R5 done timeout", 0, 1);
  endtask

  // Each entry: {lba, new data, expected data store, expected check store}
  localparam int NV = 9;
  localparam logic [LW+DW+2*SW-1:0] WVEC [NV] = '{
    {6'd0,  16'h1234, 2'd0, 2'd3},
    {6'd4,  16'hBEEF, 2'd1, 2'd2},
    {6'd8,  16'h0F0F, 2'd3, 2'd1},
    {6'd11, 16'hFFFF, 2'd3, 2'd0},
    {6'd12, 16'h0000, 2'd0, 2'd3},
    {6'd47, 16'h5A5A, 2'd3, 2'd0},
    {6'd5,  16'hC3C3, 2'd3, 2'd2},
    {6'd7,  16'h7E81, 2'd2, 2'd1},
    {6'd0,  16'h4321, 2'd0, 2'd3}
  };

  task automatic do_write(input int lba, input logic [DW-1:0] data, input int ed, input int ep);
    int row, base, dc;
    logic [DW-1:0] od, op, xr;
    row  = lba / (N - 1);
    od   = mem[ed][row];
    op   = mem[ep][row];
    base = log_n;
    @(negedge clk);
    req_valid = 1'b1; req_rebuild = 1'b0; req_lba = LW'(lba); req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(dc);
    chk(log_n - base == 4, "R2 access count", log_n - base, 4);
    chk(!log_wr[base] && log_disk[base] == ed && log_row[base] == row,
        "R1 R2 first read on data store", log_disk[base], ed);
    chk(!log_wr[base+1] && log_disk[base+1] == ep && log_row[base+1] == row,
        "R1 R2 second read on check store", log_disk[base+1], ep);
    chk(log_wr[base+2] && log_disk[base+2] == ed && log_data[base+2] == data,
        "R4 data write", log_data[base+2], data);
    chk(log_wr[base+3] && log_disk[base+3] == ep && log_data[base+3] == (op ^ od ^ data),
        "R3 check write value", log_data[base+3], op ^ od ^ data);
    chk(dc - log_cyc[base+3] == 1, "R5 done latency", dc - log_cyc[base+3], 1);
    xr = '0;
    for (int d = 0; d < N; d++) xr = xr ^ mem[d][row];
    chk(xr == '0 && mem[ed][row] == data, "R3 R4 stripe after write", xr, 0);
  endtask

  task automatic do_rebuild(input int row, input int fl);
    int base, dc, prev;
    logic [DW-1:0] exp_v;
    exp_v = mem[fl][row];
    base  = log_n;
    @(negedge clk);
    req_valid = 1'b1; req_rebuild = 1'b1; req_row = RW'(row); req_fail = SW'(fl);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(dc);
    chk(rebuild_data == exp_v, "R6 rebuilt word", rebuild_data, exp_v);
    chk(log_n - base == N - 1, "R6 read count", log_n - base, N - 1);
    prev = -1;
    for (int i = base; i < log_n; i++) begin
      chk(!log_wr[i] && log_disk[i] != fl && log_disk[i] > prev && log_row[i] == row,
          "R6 read order", log_disk[i], fl);
      prev = log_disk[i];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !done && dsk_rd_en == 0 && dsk_wr_en == 0, "R7 during reset",
        {req_ready, done}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && dsk_rd_en == 0 && dsk_wr_en == 0, "R7 after reset",
        {req_ready, done}, 2'b10);

    do_rebuild(0, 0);
    do_rebuild(5, 2);
    do_rebuild(15, 3);

    for (int i = 0; i < NV; i++) begin
      logic [LW+DW+2*SW-1:0] v;
      v = WVEC[i];
      do_write(int'(v[2*SW+DW +: LW]), v[2*SW +: DW], int'(v[SW +: SW]), int'(v[0 +: SW]));
    end

    do_rebuild(1, 1);
    do_rebuild(2, 3);

    // R8: request raised while busy has no effect
    begin
      int base, dc, after;
      logic [DW-1:0] keep;
      keep = mem[2][4];
      base = log_n;
      @(negedge clk);
      req_valid = 1'b1; req_rebuild = 1'b0; req_lba = 6'd13; req_data = 16'h9999;
      @(negedge clk);
      req_lba = 6'd14; req_data = 16'h6666;
      chk(!req_ready, "R8 ready low while busy", req_ready, 0);
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(dc);
      after = log_n;
      repeat (6) @(negedge clk);
      chk(log_n == after && after - base == 4, "R8 no extra access", log_n - base, 4);
      chk(mem[2][4] == keep && mem[1][4] == 16'h9999, "R8 ignored request", mem[2][4], keep);
    end

    for (int r = 0; r < ROWS; r++) begin
      logic [DW-1:0] xr;
      xr = '0;
      for (int d = 0; d < N; d++) xr = xr ^ mem[d][r];
      chk(xr == '0, "R3 row parity zero", xr, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule